// File: doc/BRIEF.md
# Exact-Match Destination Address Filter

This block decides, for every received Ethernet frame, whether the frame is addressed to this station. It keeps a table of sixteen 48-bit addresses. The decision is an exact comparison of the frame's destination address against every table entry. A promiscuous control input overrides the table and accepts every frame. For each frame the block also reports a status: a byte count that includes the 4-byte FCS, and an error summary.

The table is not written through registers. It is loaded by streaming a 192-byte setup frame into a separate byte port. The setup frame holds sixteen 12-byte slots, one per entry. Only six fixed byte positions in each slot carry address bytes; the other six bytes of the slot are ignored. The new contents take effect all at once, and only when the setup frame ends exactly on its 192nd byte. A setup frame that is too short or too long is thrown away, and the table already in force stays.

The receive side takes one byte per cycle, with start and end markers. The accept/reject decision is registered on the clock edge that takes the sixth byte. Downstream logic can therefore drop or keep the frame while the rest of it is still arriving.

Top module: `addr_filter`

## Requirements
- R1: After reset, filt_done and stat_valid are low. The table is empty, so every destination address, including all-zeros and all-ones, is rejected while promisc_en is low.
- R2: Setup byte k (counting from 0) belongs to entry k/12 at offset k%12. Offsets 0, 1, 4, 5, 8 and 9 are destination bytes 0 to 5, and byte 0 is the first byte on the wire. All other offsets are ignored.
- R3: The table is replaced only when setup_last comes with the 192nd setup byte. The new table is used for decisions from the next cycle on. A decision made in the same cycle as that last setup byte uses the old table.
- R4: If setup_last comes with any other byte count, the table is left unchanged. This covers both short and long setup frames.
- R5: Once a table is loaded, a frame is accepted exactly when its six destination bytes equal at least one of the sixteen entries.
- R6: filt_done pulses for one cycle after the edge that takes the sixth byte of a frame. It pulses exactly once per frame, and never for a frame shorter than six bytes. filt_accept is valid while filt_done is high.
- R7: When promisc_en is high in the cycle of the sixth byte, the frame is accepted whatever the table holds.
- R8: stat_valid pulses for one cycle after the edge that takes the byte marked rx_eof. stat_len then holds the number of bytes from rx_sof through rx_eof inclusive, FCS included, saturating at 16383.
- R9: stat_err is high when any byte of the frame had rx_err set, when the frame is shorter than 6 bytes, or when it is longer than 1536 bytes.
- R10: Bytes with rx_valid high that arrive outside a frame are ignored. A frame begins at a byte carrying rx_sof, and any such stray bytes produce neither filt_done nor stat_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| promisc_en | input | 1 | Accept every frame when high |
| setup_valid | input | 1 | Setup byte present |
| setup_data | input | 8 | Setup frame byte |
| setup_last | input | 1 | Final byte of the setup frame |
| rx_valid | input | 1 | Receive byte present |
| rx_data | input | 8 | Receive byte |
| rx_sof | input | 1 | First byte of a frame |
| rx_eof | input | 1 | Last byte of a frame |
| rx_err | input | 1 | Line error on this byte |
| filt_done | output | 1 | Filter decision pulse |
| filt_accept | output | 1 | Decision: 1 accept, 0 reject |
| stat_valid | output | 1 | Frame status pulse |
| stat_len | output | 14 | Frame length in bytes, FCS included |
| stat_err | output | 1 | Error summary |

## Verification
Two functions can fall in the same cycle: the commit of a new table and a destination decision. The bench provokes this by running a setup load and a receive frame in parallel. They are timed so that the last setup byte and the sixth destination byte meet at the same clock edge. The frame's address appears only in the new table, so a correct design rejects it. A frame sent with the same address straight afterwards must be accepted.

// File: rtl/addr_filter_pkg.sv
// Shared types and layout constants for the exact-match address filter.
// Assumes a 6-byte destination address and a 12-byte setup slot per entry.
package addr_filter_pkg;
    localparam int ADDR_BYTES  = 6;
    localparam int ENTRY_BYTES = 12;
    typedef logic [8*ADDR_BYTES-1:0] mac_t;
endpackage

// File: rtl/setup_loader.sv
// Parses the setup byte stream into a staging table and flags a commit
// when the stream ends exactly on its last byte.
// Assumes one byte per cycle; the 12-byte slot layout is fixed by the package.
module setup_loader
    import addr_filter_pkg::*;
#(
    parameter int N_ENTRIES = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       s_valid,
    input  logic [7:0] s_data,
    input  logic       s_last,
    output mac_t       stage_o [N_ENTRIES],
    output logic       commit_o
);
    localparam int EW = $clog2(N_ENTRIES + 1);
    localparam int IW = $clog2(N_ENTRIES);
    localparam int PW = $clog2(ENTRY_BYTES);

    logic [EW-1:0] ent_q;
    logic [PW-1:0] pos_q;
    mac_t          stage_q [N_ENTRIES];
    logic          in_range;
    logic          slot_ok;
    logic [2:0]    slot;

    // Offsets 0,1,4,5,8,9 carry address bytes; the word index and the low bit give the lane.
    always_comb begin
        in_range = (ent_q < EW'(N_ENTRIES));
        slot_ok  = !pos_q[1];
        slot     = {pos_q[3:2], pos_q[0]};
        commit_o = s_valid && s_last && (ent_q == EW'(N_ENTRIES - 1))
                   && (pos_q == PW'(ENTRY_BYTES - 1));
    end

    // Byte position tracker; restarts at every last byte, parks on overrun.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_q <= '0;
            pos_q <= '0;
        end else if (s_valid) begin
            if (s_last) begin
                ent_q <= '0;
                pos_q <= '0;
            end else if (in_range) begin
                if (pos_q == PW'(ENTRY_BYTES - 1)) begin
                    pos_q <= '0;
                    ent_q <= ent_q + 1'b1;
                end else begin
                    pos_q <= pos_q + 1'b1;
                end
            end
        end
    end

    // Staging table write; address byte 0 lands in the most significant lane.
    always_ff @(posedge clk) begin
        if (s_valid && in_range && slot_ok)
            stage_q[ent_q[IW-1:0]][8*(ADDR_BYTES-1-int'(slot)) +: 8] <= s_data;
    end

    assign stage_o = stage_q;

    AST_POS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        pos_q < PW'(ENTRY_BYTES)); // R2
endmodule

// File: rtl/addr_match.sv
// Holds the active address table and compares a candidate against all entries.
// Assumes the commit strobe is a single cycle and the staging table is stable then.
module addr_match
    import addr_filter_pkg::*;
#(
    parameter int N_ENTRIES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic commit_i,
    input  mac_t stage_i [N_ENTRIES],
    input  mac_t cand_i,
    output logic hit_o,
    output logic loaded_o
);
    mac_t                 act_q [N_ENTRIES];
    logic                 loaded_q;
    logic [N_ENTRIES-1:0] eq;

    // Active table: cleared at reset, replaced whole on commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            loaded_q <= 1'b0;
            for (int i = 0; i < N_ENTRIES; i++) act_q[i] <= '0;
        end else if (commit_i) begin
            loaded_q <= 1'b1;
            for (int i = 0; i < N_ENTRIES; i++) act_q[i] <= stage_i[i];
        end
    end

    // One comparator per entry.
    for (genvar g = 0; g < N_ENTRIES; g++) begin : g_cmp
        assign eq[g] = (act_q[g] == cand_i);
    end

    assign hit_o    = loaded_q && (|eq);
    assign loaded_o = loaded_q;

    AST_COMMIT_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        commit_i |=> loaded_o); // R3
    AST_STAYS_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
        loaded_o |=> loaded_o); // R4
endmodule

// File: rtl/rx_track.sv
// Follows the receive byte stream: frame state, length, error summary and
// the destination shift register; flags the cycle of the last address byte.
// Assumes one byte per cycle and that rx_sof starts a frame.
module rx_track
    import addr_filter_pkg::*;
#(
    parameter int LEN_W     = 14,
    parameter int MAX_FRAME = 1536
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid_i,
    input  logic [7:0]       data_i,
    input  logic             sof_i,
    input  logic             eof_i,
    input  logic             err_i,
    output mac_t             cand_o,
    output logic             decide_o,
    output logic             stat_valid_o,
    output logic [LEN_W-1:0] stat_len_o,
    output logic             stat_err_o
);
    localparam logic [LEN_W-1:0] LEN_MAX = '1;

    logic                         in_frame_q;
    logic [LEN_W-1:0]             len_q;
    logic                         err_q;
    logic [8*(ADDR_BYTES-1)-1:0]  dst_q;
    logic                         take;
    logic [LEN_W-1:0]             len_nx;
    logic                         err_nx;

    // Next-state terms for the byte being taken.
    always_comb begin
        take     = valid_i && (sof_i || in_frame_q);
        len_nx   = sof_i ? LEN_W'(1) : ((len_q == LEN_MAX) ? len_q : len_q + 1'b1);
        err_nx   = (sof_i ? 1'b0 : err_q) | err_i;
        decide_o = take && !sof_i && (len_q == LEN_W'(ADDR_BYTES - 1));
        cand_o   = {dst_q, data_i};
    end

    // Frame state, running length, error and destination history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_frame_q <= 1'b0;
            len_q      <= '0;
            err_q      <= 1'b0;
            dst_q      <= '0;
        end else if (take) begin
            in_frame_q <= !eof_i;
            len_q      <= len_nx;
            err_q      <= err_nx;
            dst_q      <= {dst_q[8*(ADDR_BYTES-2)-1:0], data_i};
        end
    end

    // Status word, issued on the edge that takes the end-of-frame byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_valid_o <= 1'b0;
            stat_len_o   <= '0;
            stat_err_o   <= 1'b0;
        end else begin
            stat_valid_o <= take && eof_i;
            if (take && eof_i) begin
                stat_len_o <= len_nx;
                stat_err_o <= err_nx || (len_nx < LEN_W'(ADDR_BYTES))
                              || (len_nx > LEN_W'(MAX_FRAME));
            end
        end
    end

    AST_SHORT_IS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_valid_o && (stat_len_o < LEN_W'(ADDR_BYTES))) |-> stat_err_o); // R9
    AST_STAT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        stat_valid_o |=> !stat_valid_o || $past(sof_i)); // R8
endmodule

// File: rtl/addr_filter.sv
// Top of the exact-match destination filter: setup parsing, active table,
// receive tracking and the registered accept/reject decision.
// Assumes decisions are consumed in the cycle filt_done is high.
module addr_filter
    import addr_filter_pkg::*;
#(
    parameter int N_ENTRIES = 16,
    parameter int LEN_W     = 14,
    parameter int MAX_FRAME = 1536
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             promisc_en,
    input  logic             setup_valid,
    input  logic [7:0]       setup_data,
    input  logic             setup_last,
    input  logic             rx_valid,
    input  logic [7:0]       rx_data,
    input  logic             rx_sof,
    input  logic             rx_eof,
    input  logic             rx_err,
    output logic             filt_done,
    output logic             filt_accept,
    output logic             stat_valid,
    output logic [LEN_W-1:0] stat_len,
    output logic             stat_err
);
    mac_t stage [N_ENTRIES];
    mac_t cand;
    logic commit;
    logic hit;
    logic loaded;
    logic decide;

    setup_loader #(.N_ENTRIES(N_ENTRIES)) u_loader (
        .clk(clk), .rst_n(rst_n), .s_valid(setup_valid), .s_data(setup_data),
        .s_last(setup_last), .stage_o(stage), .commit_o(commit)
    );

    addr_match #(.N_ENTRIES(N_ENTRIES)) u_match (
        .clk(clk), .rst_n(rst_n), .commit_i(commit), .stage_i(stage),
        .cand_i(cand), .hit_o(hit), .loaded_o(loaded)
    );

    rx_track #(.LEN_W(LEN_W), .MAX_FRAME(MAX_FRAME)) u_rx (
        .clk(clk), .rst_n(rst_n), .valid_i(rx_valid), .data_i(rx_data),
        .sof_i(rx_sof), .eof_i(rx_eof), .err_i(rx_err), .cand_o(cand),
        .decide_o(decide), .stat_valid_o(stat_valid), .stat_len_o(stat_len),
        .stat_err_o(stat_err)
    );

    // Decision register: promiscuous override or a table hit on the sixth byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            filt_done   <= 1'b0;
            filt_accept <= 1'b0;
        end else begin
            filt_done <= decide;
            if (decide) filt_accept <= promisc_en || hit;
        end
    end

    AST_ONE_DECISION: assert property (@(posedge clk) disable iff (!rst_n)
        filt_done |=> !filt_done); // R6
    AST_PROMISC_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (filt_done && $past(promisc_en)) |-> filt_accept); // R7
    AST_EMPTY_REJECTS: assert property (@(posedge clk) disable iff (!rst_n)
        (filt_done && !$past(promisc_en) && !$past(loaded)) |-> !filt_accept); // R1
endmodule

// File: tb/addr_filter_bench.sv
module addr_filter_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        promisc_en = 1'b0;
    logic        setup_valid = 1'b0;
    logic [7:0]  setup_data = '0;
    logic        setup_last = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_sof = 1'b0;
    logic        rx_eof = 1'b0;
    logic        rx_err = 1'b0;
    logic        filt_done;
    logic        filt_accept;
    logic        stat_valid;
    logic [13:0] stat_len;
    logic        stat_err;

    addr_filter u_addr_filter (
        .clk(clk), .rst_n(rst_n), .promisc_en(promisc_en),
        .setup_valid(setup_valid), .setup_data(setup_data), .setup_last(setup_last),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_sof(rx_sof), .rx_eof(rx_eof),
        .rx_err(rx_err), .filt_done(filt_done), .filt_accept(filt_accept),
        .stat_valid(stat_valid), .stat_len(stat_len), .stat_err(stat_err)
    );

    always #4 clk = ~clk; // 125 MHz

    int tests = 0;
    int fails = 0;
    int done_cnt = 0;
    int stat_cnt = 0;
    bit acc_last = 0;
    int len_last = 0;
    bit err_last = 0;

    logic [47:0] tab_a [16];
    logic [47:0] tab_b [16];
    logic [47:0] cur [16];
    bit loaded_m = 0;

    // Output monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (filt_done) begin done_cnt++; acc_last = filt_accept; end
        if (stat_valid) begin stat_cnt++; len_last = int'(stat_len); err_last = stat_err; end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit in_tbl(input logic [47:0] a);
        bit r = 0;
        for (int j = 0; j < 16; j++) if (loaded_m && cur[j] == a) r = 1;
        return r;
    endfunction

    task automatic load_setup(input logic [47:0] t [16], input int nbytes, input int seed);
        for (int k = 0; k < nbytes; k++) begin
            int e = k / 12;
            int p = k % 12;
            int s = (p / 4) * 2 + (p % 2);
            @(negedge clk);
            setup_valid = 1'b1;
            setup_last  = (k == nbytes - 1);
            if (e < 16 && (p % 4) < 2) setup_data = t[e][8*(5-s) +: 8];
            else setup_data = 8'(k * 7 + seed * 13 + 8'h5A);
        end
        @(negedge clk);
        setup_valid = 1'b0;
        setup_last  = 1'b0;
    endtask

    task automatic send_frame(input logic [47:0] dst, input int len, input int err_at,
                              input bit exp_acc, input string tag);
        int  exp_len;
        bit  exp_err;
        done_cnt = 0;
        stat_cnt = 0;
        for (int k = 0; k < len; k++) begin
            @(negedge clk);
            rx_valid = 1'b1;
            rx_sof   = (k == 0);
            rx_eof   = (k == len - 1);
            rx_err   = (k == err_at);
            rx_data  = (k < 6) ? dst[8*(5-k) +: 8] : 8'(k);
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_err = 1'b0;
        @(negedge clk);
        @(negedge clk);
        exp_len = (len > 16383) ? 16383 : len;
        exp_err = (err_at >= 0 && err_at < len) || len < 6 || len > 1536;
        chk(done_cnt == ((len >= 6) ? 1 : 0), {tag, " R6 decision count"}, done_cnt, (len >= 6) ? 1 : 0);
        if (len >= 6) chk(acc_last == exp_acc, {tag, " accept"}, int'(acc_last), int'(exp_acc));
        chk(stat_cnt == 1, {tag, " R8 status count"}, stat_cnt, 1);
        chk(len_last == exp_len, {tag, " R8 length"}, len_last, exp_len);
        chk(err_last == exp_err, {tag, " R9 error"}, int'(err_last), int'(exp_err));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        tab_a[0] = '1;
        tab_b[0] = '1;
        for (int i = 1; i < 16; i++) begin
            tab_a[i] = 48'h02005E100000 + 48'(i * 37);
            tab_b[i] = tab_a[i] ^ 48'h00000000FF00;
        end
        for (int i = 0; i < 16; i++) cur[i] = '0;

        repeat (4) @(negedge clk);
        chk(filt_done == 1'b0, "R1 reset filt_done", int'(filt_done), 0);
        chk(stat_valid == 1'b0, "R1 reset stat_valid", int'(stat_valid), 0);
        rst_n = 1'b1;

        send_frame(48'h0, 8, -1, 0, "R1 zero dst empty");
        send_frame('1, 8, -1, 0, "R1 broadcast empty");

        promisc_en = 1'b1;
        send_frame(48'h123456789ABC, 8, -1, 1, "R7 promisc empty");
        promisc_en = 1'b0;

        // R2/R5: load A, sweep exact hits and every single-bit miss.
        load_setup(tab_a, 192, 0);
        for (int i = 0; i < 16; i++) cur[i] = tab_a[i];
        loaded_m = 1;
        for (int i = 0; i < 16; i++) send_frame(tab_a[i], 8, -1, 1, "R5 exact hit");
        for (int i = 0; i < 16; i++)
            for (int b = 0; b < 48; b++) begin
                logic [47:0] c = tab_a[i] ^ (48'h1 << b);
                send_frame(c, 8, -1, in_tbl(c), "R2 R5 bit miss");
            end

        // R2: different filler bytes change nothing.
        load_setup(tab_a, 192, 9);
        send_frame(tab_a[7], 8, -1, 1, "R2 filler ignored hit");
        send_frame(tab_a[7] ^ 48'h1, 8, -1, in_tbl(tab_a[7] ^ 48'h1), "R2 filler ignored miss");

        promisc_en = 1'b1;
        send_frame(48'hDEADBEEF0001, 8, -1, 1, "R7 promisc loaded");
        promisc_en = 1'b0;

        // R4: short and long setup frames are discarded.
        load_setup(tab_b, 191, 1);
        send_frame(tab_a[3], 8, -1, 1, "R4 short keeps old");
        send_frame(tab_b[3], 8, -1, 0, "R4 short no new");
        load_setup(tab_b, 193, 2);
        send_frame(tab_a[3], 8, -1, 1, "R4 long keeps old");
        send_frame(tab_b[3], 8, -1, 0, "R4 long no new");
        load_setup(tab_b, 12, 3);
        send_frame(tab_a[5], 8, -1, 1, "R4 tiny keeps old");

        // R3: commit edge coincides with the sixth destination byte.
        fork
            load_setup(tab_b, 192, 4);
            begin
                repeat (186) @(negedge clk);
                send_frame(tab_b[3], 8, -1, 0, "R3 same-cycle uses old");
            end
        join
        for (int i = 0; i < 16; i++) cur[i] = tab_b[i];
        send_frame(tab_b[3], 8, -1, 1, "R3 new table in force");
        send_frame(tab_a[3], 8, -1, 0, "R3 old entry gone");

        // R8/R9: length sweep and error sources.
        for (int n = 1; n <= 14; n++) send_frame('1, n, -1, 1, "R8 R9 length sweep");
        send_frame('1, 1536, -1, 1, "R9 max length ok");
        send_frame('1, 1537, -1, 1, "R9 over length");
        send_frame('1, 20, 10, 1, "R9 line error mid");
        send_frame('1, 8, 0, 1, "R9 line error first");

        // R10: stray bytes without a start marker.
        done_cnt = 0;
        stat_cnt = 0;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            rx_valid = 1'b1;
            rx_data  = 8'hFF;
            rx_eof   = (k == 9);
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_eof = 1'b0;
        repeat (3) @(negedge clk);
        chk(done_cnt == 0, "R10 stray no decision", done_cnt, 0);
        chk(stat_cnt == 0, "R10 stray no status", stat_cnt, 0);
        send_frame(tab_b[9], 8, -1, 1, "R10 frame after stray");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule